// File: doc/BRIEF.md
# Masked Dual-Width Vector Popcount

This block counts the one bits in every element of a 512-bit vector operand and returns the counts in a 512-bit result. A run-time select decides how the vector is divided. It is either sixteen 32-bit elements or eight 64-bit elements. Each count is placed in the same element position it came from, with zeros above it to fill the element.

A 16-bit write mask picks which elements receive their count. Only the low eight mask bits are used when the elements are 64 bits wide. An element whose mask bit is clear takes one of two values, chosen by a policy input. It is either cleared to zero, or it takes the matching element of a separate merge vector.

The result is registered once. An input beat marked by `in_valid` appears on the output one clock later, and `out_valid` is high for that one cycle.

Top module: `vec_popcnt_masked`

## Requirements
- R1: After reset (`rst_n` low), `out_valid` is 0 and `vec_out` is all zeros.
- R2: `out_valid` equals the value `in_valid` had one clock earlier, so each accepted beat produces exactly one single-cycle pulse.
- R3: With `elem_wide`=0 and mask bit k set (k=0..15), bits [32k+31:32k] of `vec_out` hold the number of ones in bits [32k+31:32k] of `vec_in`.
- R4: With `elem_wide`=1 and mask bit k set (k=0..7), bits [64k+63:64k] of `vec_out` hold the number of ones in bits [64k+63:64k] of `vec_in`, zero-extended. An all-ones element gives 64, and the upper 32 bits of the element are zero.
- R5: With `zero_unmasked`=1, every element whose mask bit is clear is all zeros in `vec_out`, in either element size.
- R6: With `zero_unmasked`=0, every element whose mask bit is clear is a full-width copy of the matching element of `merge_src`. That copy is 32 bits wide in narrow mode and 64 bits wide in wide mode.
- R7: With `elem_wide`=1, `wr_mask[15:8]` has no effect on `vec_out`.
- R8: When `in_valid` is 0, `vec_out` keeps its previous value at the next clock edge.
- R9: With `elem_wide`=0, an all-ones 32-bit element gives a count of 32 and an all-zeros element gives a count of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operand beat is present this cycle |
| elem_wide | input | 1 | Element size: 0 = sixteen 32-bit elements, 1 = eight 64-bit elements |
| zero_unmasked | input | 1 | Policy for unmasked elements: 1 = zero them, 0 = copy them from `merge_src` |
| wr_mask | input | 16 | Per-element write mask; bit k selects element k |
| vec_in | input | 512 | Vector whose elements are counted |
| merge_src | input | 512 | Source of the unmasked elements in merge policy |
| out_valid | output | 1 | Result beat valid, one cycle after `in_valid` |
| vec_out | output | 512 | Registered result vector |

## Verification
The assertions assume that `in_valid`, `elem_wide`, `zero_unmasked` and `wr_mask` are known, 0 or 1, on every clock edge after reset. They also assume that the data vectors are known whenever `in_valid` is high, because the per-element checks compare against the previous cycle's operands.

The bench drives every input to a defined value from the first cycle. When `in_valid` is low it still drives fully defined data, which lets the hold behaviour be observed.

The random stimulus mixes dense, sparse and all-ones/all-zeros elements across both element sizes and both policies. This keeps the counts spread over their whole range, including the top values of 32 and 64.

// File: rtl/vpc_pkg.sv
// Package: shared encodings for the masked vector popcount.
// Assumes: nothing; holds only type definitions.
package vpc_pkg;
    // Element size selected by the elem_wide input
    typedef enum logic {
        ELEM_NARROW = 1'b0,
        ELEM_WIDE   = 1'b1
    } elem_size_e;

    // Policy for elements whose mask bit is clear
    typedef enum logic {
        FILL_MERGE = 1'b0,
        FILL_ZERO  = 1'b1
    } fill_policy_e;
endpackage

// File: rtl/vpc_lane_count.sv
// Module: vpc_lane_count
// Counts the one bits of a single narrow lane.
// Assumes: CNT_W is wide enough to hold LANE_W.
module vpc_lane_count #(
    parameter int LANE_W = 32,
    parameter int CNT_W  = $clog2(LANE_W + 1)
) (
    input  logic [LANE_W-1:0] lane_bits,
    output logic [CNT_W-1:0]  lane_cnt
);
    // Add up the lane bits one at a time
    always_comb begin
        lane_cnt = '0;
        for (int b = 0; b < LANE_W; b++) begin
            lane_cnt = lane_cnt + CNT_W'(lane_bits[b]);
        end
    end
endmodule

// File: rtl/vpc_pair_sum.sv
// Module: vpc_pair_sum
// Forms the wide-element counts by adding neighbouring lane counts.
// Assumes: LANES is even; lane 2p is the low half of wide element p.
module vpc_pair_sum #(
    parameter int LANES  = 16,
    parameter int CNT_W  = 6,
    parameter int WCNT_W = CNT_W + 1
) (
    input  logic [LANES-1:0][CNT_W-1:0]    lane_cnt,
    output logic [LANES/2-1:0][WCNT_W-1:0] pair_cnt
);
    localparam int PAIRS = LANES / 2;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        // Sum of the low and high lane counts of one wide element
        assign pair_cnt[p] = WCNT_W'(lane_cnt[2*p]) + WCNT_W'(lane_cnt[2*p+1]);
    end
endmodule

// File: rtl/vpc_mask_select.sv
// Module: vpc_mask_select
// Chooses, for each 32-bit lane, between the count, zero and the merge source.
// Assumes: in wide mode, wide element p occupies lanes 2p (low) and 2p+1 (high);
//          only mask bits [LANES/2-1:0] are used in wide mode.
module vpc_mask_select
    import vpc_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int LANE_W = 32,
    parameter int CNT_W  = 6,
    parameter int WCNT_W = 7
) (
    input  elem_size_e                      elem_size,
    input  fill_policy_e                    fill_policy,
    input  logic [LANES-1:0]                wr_mask,
    input  logic [LANES-1:0][CNT_W-1:0]     lane_cnt,
    input  logic [LANES/2-1:0][WCNT_W-1:0]  pair_cnt,
    input  logic [LANES*LANE_W-1:0]         merge_src,
    output logic [LANES*LANE_W-1:0]         result
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int PAIR = j / 2;
        localparam bit HIGH = (j % 2) == 1;

        logic              lane_en;
        logic [LANE_W-1:0] count_word;
        logic [LANE_W-1:0] fill_word;

        // Mask bit governing this lane under the current element size
        assign lane_en = (elem_size == ELEM_WIDE) ? wr_mask[PAIR] : wr_mask[j];

        // Zero-extended count for this lane; wide high halves carry zeros
        always_comb begin
            if (elem_size == ELEM_WIDE) begin
                count_word = HIGH ? '0 : {{(LANE_W-WCNT_W){1'b0}}, pair_cnt[PAIR]};
            end else begin
                count_word = {{(LANE_W-CNT_W){1'b0}}, lane_cnt[j]};
            end
        end

        // Value for a lane whose element is not written
        assign fill_word = (fill_policy == FILL_ZERO) ? '0 : merge_src[j*LANE_W +: LANE_W];

        // Final lane value
        assign result[j*LANE_W +: LANE_W] = lane_en ? count_word : fill_word;
    end
endmodule

// File: rtl/vec_popcnt_masked.sv
// Module: vec_popcnt_masked (top)
// Per-element population count of a vector split into narrow or wide
// elements, with masked writes that zero or merge, and a single output register.
// Assumes: VEC_W is an even multiple of LANE_W; wide elements are 2*LANE_W bits.
module vec_popcnt_masked
    import vpc_pkg::*;
#(
    parameter int VEC_W  = 512,
    parameter int LANE_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    elem_wide,
    input  logic                    zero_unmasked,
    input  logic [VEC_W/LANE_W-1:0] wr_mask,
    input  logic [VEC_W-1:0]        vec_in,
    input  logic [VEC_W-1:0]        merge_src,
    output logic                    out_valid,
    output logic [VEC_W-1:0]        vec_out
);
    localparam int LANES  = VEC_W / LANE_W;
    localparam int PAIRS  = LANES / 2;
    localparam int CNT_W  = $clog2(LANE_W + 1);
    localparam int WCNT_W = $clog2(2 * LANE_W + 1);

    elem_size_e                  elem_size;
    fill_policy_e                fill_policy;
    logic [LANES-1:0][CNT_W-1:0] lane_cnt;
    logic [PAIRS-1:0][WCNT_W-1:0] pair_cnt;
    logic [VEC_W-1:0]            next_result;

    // Decode the mode inputs into named encodings
    assign elem_size   = elem_size_e'(elem_wide);
    assign fill_policy = fill_policy_e'(zero_unmasked);

    for (genvar j = 0; j < LANES; j++) begin : g_count
        vpc_lane_count #(
            .LANE_W (LANE_W),
            .CNT_W  (CNT_W)
        ) u_count (
            .lane_bits (vec_in[j*LANE_W +: LANE_W]),
            .lane_cnt  (lane_cnt[j])
        );
    end

    vpc_pair_sum #(
        .LANES  (LANES),
        .CNT_W  (CNT_W),
        .WCNT_W (WCNT_W)
    ) u_pairs (
        .lane_cnt (lane_cnt),
        .pair_cnt (pair_cnt)
    );

    vpc_mask_select #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .CNT_W  (CNT_W),
        .WCNT_W (WCNT_W)
    ) u_select (
        .elem_size   (elem_size),
        .fill_policy (fill_policy),
        .wr_mask     (wr_mask),
        .lane_cnt    (lane_cnt),
        .pair_cnt    (pair_cnt),
        .merge_src   (merge_src),
        .result      (next_result)
    );

    // Output stage: pulse valid one clock after input, capture result on input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                vec_out <= next_result;
            end
        end
    end
endmodule

// File: rtl/vpc_checker.sv
// Module: vpc_checker
// Temporal checks on the popcount block, attached to the top by bind.
// Assumes: control inputs are known on every edge after reset.
module vpc_checker #(
    parameter int VEC_W  = 512,
    parameter int LANE_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    elem_wide,
    input logic                    zero_unmasked,
    input logic [VEC_W/LANE_W-1:0] wr_mask,
    input logic [VEC_W-1:0]        vec_in,
    input logic [VEC_W-1:0]        merge_src,
    input logic                    out_valid,
    input logic [VEC_W-1:0]        vec_out
);
    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(vec_out));

    // R3
    narrow_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !elem_wide && wr_mask[0])
        |=> (vec_out[LANE_W-1:0] == LANE_W'($countones($past(vec_in[LANE_W-1:0])))));

    // R4
    wide_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && elem_wide && wr_mask[0]) |=> (vec_out[2*LANE_W-1:LANE_W] == '0));

    // R5
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_unmasked && !wr_mask[0]) |=> (vec_out[LANE_W-1:0] == '0));

    // R6
    merge_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zero_unmasked && !wr_mask[0])
        |=> (vec_out[LANE_W-1:0] == $past(merge_src[LANE_W-1:0])));
endmodule

bind vec_popcnt_masked vpc_checker #(
    .VEC_W  (VEC_W),
    .LANE_W (LANE_W)
) u_vpc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .elem_wide     (elem_wide),
    .zero_unmasked (zero_unmasked),
    .wr_mask       (wr_mask),
    .vec_in        (vec_in),
    .merge_src     (merge_src),
    .out_valid     (out_valid),
    .vec_out       (vec_out)
);

// File: tb/vec_popcnt_masked_test.sv
module vec_popcnt_masked_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         elem_wide = 1'b0;
    logic         zero_unmasked = 1'b0;
    logic [15:0]  wr_mask = '0;
    logic [511:0] vec_in = '0;
    logic [511:0] merge_src = '0;
    logic         out_valid;
    logic [511:0] vec_out;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vec_popcnt_masked uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem_wide(elem_wide),
        .zero_unmasked(zero_unmasked), .wr_mask(wr_mask), .vec_in(vec_in),
        .merge_src(merge_src), .out_valid(out_valid), .vec_out(vec_out)
    );

    // Expected result straight from the requirements
    function automatic logic [511:0] model(input logic wide, input logic zero,
                                           input logic [15:0] m,
                                           input logic [511:0] v, input logic [511:0] s);
        logic [511:0] r = '0;
        if (!wide) begin
            for (int e = 0; e < 16; e++)
                r[e*32 +: 32] = m[e] ? 32'($countones(v[e*32 +: 32])) : (zero ? 32'd0 : s[e*32 +: 32]);
        end else begin
            for (int e = 0; e < 8; e++)
                r[e*64 +: 64] = m[e] ? 64'($countones(v[e*64 +: 64])) : (zero ? 64'd0 : s[e*64 +: 64]);
        end
        return r;
    endfunction

    function automatic logic [511:0] rand_vec(input int style);
        logic [511:0] r;
        for (int i = 0; i < 16; i++) begin
            case (style)
                0: r[i*32 +: 32] = $urandom;
                1: r[i*32 +: 32] = $urandom & $urandom & $urandom;
                2: r[i*32 +: 32] = ($urandom % 2) ? 32'hFFFF_FFFF : 32'h0;
                default: r[i*32 +: 32] = $urandom | $urandom;
            endcase
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one beat, then check the registered result one clock later
    task automatic run(input logic wide, input logic zero, input logic [15:0] m,
                       input logic [511:0] v, input logic [511:0] s, input string tag);
        logic [511:0] exp;
        exp = model(wide, zero, m, v, s);
        @(negedge clk);
        in_valid = 1'b1; elem_wide = wide; zero_unmasked = zero;
        wr_mask = m; vec_in = v; merge_src = s;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R2 valid pulse", {511'd0, out_valid}, 512'd1);
        check(vec_out === exp, tag, vec_out, exp);
    endtask

    initial begin
        logic [511:0] held;
        logic [511:0] v;
        logic [511:0] s;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1 out_valid reset", {511'd0, out_valid}, 512'd0);
        check(vec_out === '0, "R1 vec_out reset", vec_out, 512'd0);
        rst_n = 1'b1;

        // R9: all ones / all zeros narrow
        run(1'b0, 1'b1, 16'hFFFF, {16{32'hFFFF_FFFF}}, '0, "R9 all-ones narrow gives 32");
        run(1'b0, 1'b1, 16'hFFFF, '0, {16{32'h1234_5678}}, "R9 all-zeros narrow gives 0");
        // R4: all ones wide gives 64
        run(1'b1, 1'b1, 16'h00FF, {16{32'hFFFF_FFFF}}, '0, "R4 all-ones wide gives 64");
        // R3: mixed narrow counts
        v = rand_vec(0);
        run(1'b0, 1'b0, 16'hFFFF, v, rand_vec(0), "R3 narrow full mask");
        // R5: zeroing with partial mask, both sizes
        run(1'b0, 1'b1, 16'hA5C3, rand_vec(3), rand_vec(0), "R5 narrow zeroing");
        run(1'b1, 1'b1, 16'h0036, rand_vec(3), rand_vec(0), "R5 wide zeroing");
        // R6: merging, both sizes
        run(1'b0, 1'b0, 16'h0F0F, rand_vec(1), rand_vec(0), "R6 narrow merge");
        run(1'b1, 1'b0, 16'h0069, rand_vec(1), rand_vec(0), "R6 wide merge 64-bit copy");
        // R7: upper mask byte ignored in wide mode
        v = rand_vec(0); s = rand_vec(0);
        run(1'b1, 1'b0, 16'h0055, v, s, "R7 wide upper mask zero");
        run(1'b1, 1'b0, 16'hAA55, v, s, "R7 wide upper mask ones");
        run(1'b1, 1'b1, 16'hFF00, v, s, "R7 wide only upper mask bits set");

        // R8 and R2: idle cycle with changed data holds the output
        held = vec_out;
        in_valid = 1'b0; vec_in = rand_vec(0); merge_src = rand_vec(0);
        wr_mask = 16'hFFFF; zero_unmasked = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R2 no pulse when idle", {511'd0, out_valid}, 512'd0);
        check(vec_out === held, "R8 output holds while idle", vec_out, held);

        // Random mix
        for (int i = 0; i < 200; i++) begin
            logic w;
            logic z;
            logic [15:0] m;
            string tag;
            w = 1'($urandom); z = 1'($urandom); m = 16'($urandom);
            if (w) tag = "R4 random wide";
            else tag = "R3 random narrow";
            run(w, z, m, rand_vec(int'($urandom % 4)), rand_vec(0), tag);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule